// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block chooses the receive sampling phase of a high-speed SD/eMMC host once a tuning sequence has run. The tuning logic probes each of the N delay taps twice. It hands the block a bitmap of 2N pass/fail results, and bits i and i+N belong to the same tap. After `start`, the block folds the two passes together, so a tap counts as good only when both of its probes passed. It then walks the 2N merged entries at one bit per clock and keeps the longest unbroken stretch of good entries. When that stretch is long enough, it reports the tap at the centre of the stretch, folded back into the range 0..N-1. Otherwise it reports a failure.

The block also holds the selection state that the rest of the host reads. This state is the chosen tap, an auto-retune enable bit, a pending retune-error flag and a double-data-rate mode flag. A successful selection writes the tap and sets the enable. The error flag is raised by the sampling monitor. A check request reports the error, but only while auto-retune is on, and the report clears the flag. Every new selection clears the flag before it starts.

N is 8 in normal mode and 4 in double-data-rate mode. When the four-tap option is set, entering that mode halves the stored tap.

Top module: `tap_window_sel`

## Requirements
- R1: A tap counts as passing only when both of its probes passed. For a tap count N, merged entries i and i+N are both `probe_map[i] & probe_map[i+N]`, for i in 0..N-1.
- R2: The block scans merged entries 0 to 2N-1 and keeps the longest run of passing entries. A later run replaces the kept run only when it is strictly longer, so on a tie the earlier run wins.
- R3: A run still open at entry 2N-1 is compared against the kept run once the scan ends.
- R4: When the kept run (start s, end e) has at least 3 entries, `tap_set` becomes ((s+e)/2) mod N, using integer division. `done` is high for exactly one cycle, and `fail` is 0 in that cycle. Take E0 as the rising edge that samples an accepted `start`. `done` is then high in the cycle that follows edge E0+2N+1, and `tap_set` takes its new value at that same edge.
- R5: When the kept run is shorter than 3 entries, `done` and `fail` are both high for that one cycle. `tap_set` and `retune_en` keep their values.
- R6: A successful selection sets `retune_en` to 1 at the same edge that raises `done`.
- R7: A `retune_err` pulse sets `retune_pend`. `retune_chk` sampled while `retune_en` and `retune_pend` are both 1 makes `retune_hit` high for one cycle after that edge, and `retune_pend` clears at the same edge. While `retune_en` is 0, a check produces no hit and leaves `retune_pend` unchanged.
- R8: An accepted `start` clears `retune_pend`. This clear takes priority over a `retune_err` pulse sampled at the same edge.
- R9: N is 8 while `ddr_active` is 0 and 4 while it is 1. In the 4-tap mode only `probe_map[7:0]` is used. `ddr_enter` sets the mode, and `ddr_leave` clears it. If `four_tap_opt` is set when the mode is entered from normal, `tap_set` is halved. Mode requests are ignored while `busy` is high or `start` is high.
- R10: `busy` is high from edge E0 up to edge E0+2N+1. A `start` sampled while `busy` is high is ignored.
- R11: Synchronous active-low reset clears `tap_set`, `retune_en`, `retune_pend`, `ddr_active`, `done`, `fail`, `retune_hit` and `busy` to 0.
- R12: `retune_off` clears `retune_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a selection, sampled when idle |
| probe_map | input | 16 | Pass/fail results, two probes per tap |
| ddr_enter | input | 1 | Enter the 4-tap double-data-rate mode |
| ddr_leave | input | 1 | Return to normal mode |
| four_tap_opt | input | 1 | Halve the tap on mode entry |
| retune_off | input | 1 | Clear the auto-retune enable |
| retune_err | input | 1 | Sampling error seen by the monitor |
| retune_chk | input | 1 | Request an error report |
| done | output | 1 | One-cycle selection complete |
| fail | output | 1 | Selection failed, valid with done |
| tap_set | output | 3 | Selected sampling tap |
| retune_en | output | 1 | Auto-retune enabled |
| retune_pend | output | 1 | Retune error pending |
| retune_hit | output | 1 | One-cycle error report |
| ddr_active | output | 1 | 4-tap mode active |
| busy | output | 1 | Selection in progress |

## Verification
A wrong run length or a wrong start index inside the scanner shows up only at the end of the scan. It appears as a wrong `tap_set`, or as a wrong `fail`, in the single `done` cycle 2N+2 cycles after start. The bench therefore uses bitmaps whose winning window is unique, tied, open at the end, folded past N, or exactly at the length threshold. A wrong state in the retune or mode flags shows up at the ports within one cycle, because those bits drive `retune_en`, `retune_pend`, `retune_hit`, `ddr_active` and the halved `tap_set` directly. The reference model is compared with these outputs on every clock.

// File: rtl/tws_pkg.sv
// Package: shared types for the sampling tap window selector.
// Assumes: nothing beyond IEEE 1800-2017.
package tws_pkg;

    // Scanner sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } scan_state_t;

endpackage

// File: rtl/tws_merge.sv
// Module: tws_merge
// Folds the two probe passes together for both tap counts. Entry i of each
// output is the AND of the two probes of tap (i mod N). Entries at and above
// 2N of the short variant are tied low.
// Assumes: NDDR <= NMAX; purely combinational.
module tws_merge #(
    parameter int NMAX = 8,
    parameter int NDDR = 4,
    localparam int MAPW = 2 * NMAX
) (
    input  logic [MAPW-1:0] probe,
    output logic [MAPW-1:0] merged_norm,
    output logic [MAPW-1:0] merged_ddr
);

    // One AND gate per entry for each tap-count variant.
    for (genvar i = 0; i < MAPW; i++) begin : g_ent
        assign merged_norm[i] = probe[i % NMAX] & probe[(i % NMAX) + NMAX];
        if (i < 2 * NDDR) begin : g_ddr
            assign merged_ddr[i] = probe[i % NDDR] & probe[(i % NDDR) + NDDR];
        end else begin : g_pad
            assign merged_ddr[i] = 1'b0;
        end
    end

endmodule

// File: rtl/tws_scan.sv
// Module: tws_scan
// Walks a latched merged bitmap one entry per clock. It tracks the current
// run and the longest run (strictly longer replaces), closes an open run in a
// final cycle, and presents the folded centre tap and the pass/fail verdict
// while in the final state.
// Assumes: go is only asserted by the parent while busy is low.
module tws_scan
    import tws_pkg::*;
#(
    parameter int TAPS_NORMAL = 8,
    parameter int TAPS_DDR    = 4,
    parameter int MIN_RUN     = 3,
    localparam int MAPW = 2 * TAPS_NORMAL,
    localparam int IW   = $clog2(MAPW),
    localparam int LW   = $clog2(MAPW + 1),
    localparam int AW   = LW + 1,
    localparam int TW   = $clog2(TAPS_NORMAL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            go_ddr,
    input  logic [MAPW-1:0] go_bits,
    output logic            busy,
    output logic            fin_valid,
    output logic            fin_ok,
    output logic [TW-1:0]   fin_tap
);

    scan_state_t     state_q;
    logic [IW-1:0]   idx_q;
    logic [LW-1:0]   run_q;
    logic [LW-1:0]   best_len_q;
    logic [IW-1:0]   best_st_q;
    logic [MAPW-1:0] bits_q;
    logic            ddr_q;

    logic [IW-1:0]   last_idx;
    logic            cur_bit;
    logic [AW-1:0]   total;
    logic [AW-1:0]   win_len;
    logic [AW-1:0]   win_st;
    logic [AW-1:0]   win_end;
    logic [AW-1:0]   win_mid;
    logic [AW-1:0]   win_fold;

    // Last index to visit and the entry under the cursor.
    always_comb begin
        last_idx = ddr_q ? IW'(2 * TAPS_DDR - 1) : IW'(2 * TAPS_NORMAL - 1);
        cur_bit  = bits_q[idx_q];
        total    = ddr_q ? AW'(2 * TAPS_DDR) : AW'(2 * TAPS_NORMAL);
    end

    // Sequencer and run tracking, one merged entry per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            run_q      <= '0;
            best_len_q <= '0;
            best_st_q  <= '0;
            bits_q     <= '0;
            ddr_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        bits_q     <= go_bits;
                        ddr_q      <= go_ddr;
                        idx_q      <= '0;
                        run_q      <= '0;
                        best_len_q <= '0;
                        best_st_q  <= '0;
                        state_q    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (cur_bit) begin
                        run_q <= run_q + 1'b1;
                    end else begin
                        if (run_q > best_len_q) begin
                            best_len_q <= run_q;
                            best_st_q  <= idx_q - run_q[IW-1:0];
                        end
                        run_q <= '0;
                    end
                    if (idx_q == last_idx) begin
                        state_q <= ST_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Close a run still open at the end and pick the winning window.
    always_comb begin
        if (run_q > best_len_q) begin
            win_len = AW'(run_q);
            win_st  = total - AW'(run_q);
        end else begin
            win_len = AW'(best_len_q);
            win_st  = AW'(best_st_q);
        end
        win_end = win_st + win_len - 1'b1;
        win_mid = (win_st + win_end) >> 1;
    end

    // Fold the centre index back into the active tap range.
    always_comb begin
        if (ddr_q) begin
            win_fold = win_mid % AW'(TAPS_DDR);
        end else begin
            win_fold = win_mid % AW'(TAPS_NORMAL);
        end
    end

    // Result presentation toward the register stage.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        fin_valid = (state_q == ST_FIN);
        fin_ok    = (win_len >= AW'(MIN_RUN));
        fin_tap   = win_fold[TW-1:0];
    end

endmodule

// File: rtl/tws_regs.sv
// Module: tws_regs
// Holds the selected tap, the auto-retune enable, the pending retune error,
// the tap-count mode and the one-cycle done/fail/hit pulses.
// Assumes: fin_valid only occurs while the parent reports busy, so a
// mode change and a result never meet at the same edge.
module tws_regs #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_acc,
    input  logic          mode_ok,
    input  logic          fin_valid,
    input  logic          fin_ok,
    input  logic [TW-1:0] fin_tap,
    input  logic          err_set,
    input  logic          chk_req,
    input  logic          en_off,
    input  logic          ddr_set,
    input  logic          ddr_clr,
    input  logic          four_tap,
    output logic [TW-1:0] tap_q,
    output logic          en_q,
    output logic          pend_q,
    output logic          ddr_q,
    output logic          done_q,
    output logic          fail_q,
    output logic          hit_q
);

    logic report;

    // A check reports only with retune on and an error pending.
    assign report = chk_req & en_q & pend_q;

    // Tap register and tap-count mode, halving on 4-tap entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
            ddr_q <= 1'b0;
        end else if (fin_valid) begin
            if (fin_ok) begin
                tap_q <= fin_tap;
            end
        end else if (mode_ok) begin
            if (ddr_set) begin
                if (!ddr_q) begin
                    ddr_q <= 1'b1;
                    if (four_tap) begin
                        tap_q <= tap_q >> 1;
                    end
                end
            end else if (ddr_clr) begin
                ddr_q <= 1'b0;
            end
        end
    end

    // Auto-retune enable: success sets it, the off request clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (fin_valid && fin_ok) begin
            en_q <= 1'b1;
        end else if (en_off) begin
            en_q <= 1'b0;
        end
    end

    // Pending retune error: a clear by start or by a report beats a new set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (start_acc || report) begin
            pend_q <= 1'b0;
        end else if (err_set) begin
            pend_q <= 1'b1;
        end
    end

    // One-cycle completion and report pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            done_q <= fin_valid;
            fail_q <= fin_valid & ~fin_ok;
            hit_q  <= report;
        end
    end

endmodule

// File: rtl/tap_window_sel.sv
// Module: tap_window_sel
// Top of the sampling tap window selector. Accepts start only when idle,
// hands the merged bitmap for the current tap count to the scanner, and
// keeps the selection and retune state in the register stage.
// Assumes: TAPS_DDR <= TAPS_NORMAL <= 16, both at least 2.
module tap_window_sel #(
    parameter int TAPS_NORMAL = 8,
    parameter int TAPS_DDR    = 4,
    parameter int MIN_RUN     = 3,
    localparam int MAPW = 2 * TAPS_NORMAL,
    localparam int TW   = $clog2(TAPS_NORMAL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MAPW-1:0] probe_map,
    input  logic            ddr_enter,
    input  logic            ddr_leave,
    input  logic            four_tap_opt,
    input  logic            retune_off,
    input  logic            retune_err,
    input  logic            retune_chk,
    output logic            done,
    output logic            fail,
    output logic [TW-1:0]   tap_set,
    output logic            retune_en,
    output logic            retune_pend,
    output logic            retune_hit,
    output logic            ddr_active,
    output logic            busy
);

    logic [MAPW-1:0] m_norm;
    logic [MAPW-1:0] m_ddr;
    logic [MAPW-1:0] m_sel;
    logic            start_acc;
    logic            mode_ok;
    logic            fin_valid;
    logic            fin_ok;
    logic [TW-1:0]   fin_tap;

    // Start acceptance and the window in which mode requests apply.
    always_comb begin
        start_acc = start & ~busy;
        mode_ok   = ~busy & ~start;
        m_sel     = ddr_active ? m_ddr : m_norm;
    end

    tws_merge #(
        .NMAX (TAPS_NORMAL),
        .NDDR (TAPS_DDR)
    ) u_merge (
        .probe       (probe_map),
        .merged_norm (m_norm),
        .merged_ddr  (m_ddr)
    );

    tws_scan #(
        .TAPS_NORMAL (TAPS_NORMAL),
        .TAPS_DDR    (TAPS_DDR),
        .MIN_RUN     (MIN_RUN)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (start_acc),
        .go_ddr    (ddr_active),
        .go_bits   (m_sel),
        .busy      (busy),
        .fin_valid (fin_valid),
        .fin_ok    (fin_ok),
        .fin_tap   (fin_tap)
    );

    tws_regs #(
        .TW (TW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .mode_ok   (mode_ok),
        .fin_valid (fin_valid),
        .fin_ok    (fin_ok),
        .fin_tap   (fin_tap),
        .err_set   (retune_err),
        .chk_req   (retune_chk),
        .en_off    (retune_off),
        .ddr_set   (ddr_enter),
        .ddr_clr   (ddr_leave),
        .four_tap  (four_tap_opt),
        .tap_q     (tap_set),
        .en_q      (retune_en),
        .pend_q    (retune_pend),
        .ddr_q     (ddr_active),
        .done_q    (done),
        .fail_q    (fail),
        .hit_q     (retune_hit)
    );

endmodule

// File: rtl/tws_checker.sv
// Module: tws_checker
// Temporal properties of the tap window selector, observed at its ports.
// Assumes: bound to every tap_window_sel instance.
module tws_checker #(
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          fail,
    input logic [TW-1:0] tap_set,
    input logic          retune_en,
    input logic          retune_pend,
    input logic          retune_hit,
    input logic          ddr_active,
    input logic          busy
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R10
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done); // R5
    AST_FAIL_KEEPS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> $stable(tap_set)); // R5
    AST_SUCCESS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> retune_en); // R6
    AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        retune_hit |-> ($past(retune_en) && $past(retune_pend))); // R7
    AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        retune_hit |-> !retune_pend); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !retune_pend); // R8
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(ddr_active)); // R9

endmodule

bind tap_window_sel tws_checker #(.TW(TW)) u_tws_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .done        (done),
    .fail        (fail),
    .tap_set     (tap_set),
    .retune_en   (retune_en),
    .retune_pend (retune_pend),
    .retune_hit  (retune_hit),
    .ddr_active  (ddr_active),
    .busy        (busy)
);

// File: tb/tb_tap_window_sel.sv
`timescale 1ns/1ps
module tb_tap_window_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] probe_map = '0;
    logic        ddr_enter = 1'b0;
    logic        ddr_leave = 1'b0;
    logic        four_tap_opt = 1'b0;
    logic        retune_off = 1'b0;
    logic        retune_err = 1'b0;
    logic        retune_chk = 1'b0;
    logic        done, fail, retune_en, retune_pend, retune_hit, ddr_active, busy;
    logic [2:0]  tap_set;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    tap_window_sel dut (
        .clk(clk), .rst_n(rst_n), .start(start), .probe_map(probe_map),
        .ddr_enter(ddr_enter), .ddr_leave(ddr_leave), .four_tap_opt(four_tap_opt),
        .retune_off(retune_off), .retune_err(retune_err), .retune_chk(retune_chk),
        .done(done), .fail(fail), .tap_set(tap_set), .retune_en(retune_en),
        .retune_pend(retune_pend), .retune_hit(retune_hit),
        .ddr_active(ddr_active), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural selection: merge, longest strictly-longer run, centre fold.
    function automatic void pick(input logic [15:0] pm, input int n,
                                 output bit ok, output int tap);
        bit good [$];
        int best = 0, bst = 0, cur = 0;
        for (int i = 0; i < 2 * n; i++) good.push_back(pm[i % n] & pm[(i % n) + n]);
        for (int i = 0; i < 2 * n; i++) begin
            if (good[i]) cur++;
            else begin
                if (cur > best) begin best = cur; bst = i - cur; end
                cur = 0;
            end
        end
        if (cur > best) begin best = cur; bst = 2 * n - cur; end
        ok  = (best >= 3);
        tap = ((bst + bst + best - 1) / 2) % n;
    endfunction

    // Reference model state.
    int m_cnt = 0, m_tap = 0, m_res_tap = 0;
    bit m_res_ok = 0, m_en = 0, m_pend = 0, m_ddr = 0, m_done = 0, m_fail = 0, m_hit = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_tap <= 0; m_en <= 0; m_pend <= 0; m_ddr <= 0;
            m_done <= 0; m_fail <= 0; m_hit <= 0;
        end else begin
            bit acc, rep, ok;
            int t;
            acc = start && (m_cnt == 0);
            rep = retune_chk && m_en && m_pend;
            m_done <= 0;
            m_fail <= 0;
            m_hit  <= rep;
            if (retune_off) m_en <= 0;
            if (acc) begin
                pick(probe_map, m_ddr ? 4 : 8, ok, t);
                m_res_ok  <= ok;
                m_res_tap <= t;
                m_cnt     <= (m_ddr ? 8 : 16) + 1;
            end else if (m_cnt > 0) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) begin
                    m_done <= 1;
                    m_fail <= !m_res_ok;
                    if (m_res_ok) begin m_tap <= m_res_tap; m_en <= 1; end
                end
            end
            if (acc || rep) m_pend <= 0;
            else if (retune_err) m_pend <= 1;
            if (m_cnt == 0 && !start) begin
                if (ddr_enter) begin
                    if (!m_ddr) begin
                        m_ddr <= 1;
                        if (four_tap_opt) m_tap <= m_tap / 2;
                    end
                end else if (ddr_leave) m_ddr <= 0;
            end
        end
    end

    // Compare every port with the model on each cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 done", done, m_done);
            chk("R5 fail", fail, m_fail);
            chk("R4 tap_set", tap_set, m_tap);
            chk("R6 retune_en", retune_en, m_en);
            chk("R8 retune_pend", retune_pend, m_pend);
            chk("R7 retune_hit", retune_hit, m_hit);
            chk("R9 ddr_active", ddr_active, m_ddr);
            chk("R10 busy", busy, m_cnt > 0);
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 20000);
            summary();
            $finish;
        end
    end

    task automatic run(input logic [15:0] pm, input bit exp_ok, input int exp_tap,
                       input string tag);
        int k = 0;
        @(negedge clk); start = 1'b1; probe_map = pm;
        @(negedge clk); start = 1'b0;
        while (done !== 1'b1 && k < 100) begin @(negedge clk); k++; end
        chk({tag, " fail flag"}, fail, !exp_ok);
        if (exp_ok) chk({tag, " tap"}, tap_set, exp_tap);
    endtask

    task automatic pulse_err;  @(negedge clk); retune_err = 1; @(negedge clk); retune_err = 0; endtask
    task automatic pulse_chk;  @(negedge clk); retune_chk = 1; @(negedge clk); retune_chk = 0; endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 tap_set", tap_set, 0);
        chk("R11 retune_en", retune_en, 0);
        chk("R11 retune_pend", retune_pend, 0);
        chk("R11 ddr_active", ddr_active, 0);
        chk("R11 done", done, 0);
        chk("R11 busy", busy, 0);
        rst_n = 1'b1;

        run(16'hFFFF, 1, 7, "R3 open run");
        run({8'h0F, 8'hFF}, 1, 1, "R1 merge");
        run({8'h7E, 8'h7E}, 1, 3, "R2 tie earlier");
        run({8'hBF, 8'hBF}, 1, 2, "R4 fold mod N");
        run({8'hE1, 8'hFF}, 1, 6, "R2 longest");
        run({8'h03, 8'h03}, 0, 0, "R5 len2");
        chk("R5 tap kept", tap_set, 6);
        run({8'h55, 8'h55}, 0, 0, "R5 alternating");
        run({8'h07, 8'h07}, 1, 1, "R5 boundary len3");

        // R10: a second start while busy is ignored.
        @(negedge clk); start = 1; probe_map = {8'hE1, 8'hE1};
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        start = 1; probe_map = 16'hFFFF;
        @(negedge clk); start = 0;
        repeat (20) @(negedge clk);
        chk("R10 first start wins", tap_set, 6);

        // R12 and R7: no report while retune is off.
        @(negedge clk); retune_off = 1; @(negedge clk); retune_off = 0;
        chk("R12 enable cleared", retune_en, 0);
        pulse_err();
        chk("R7 pend set", retune_pend, 1);
        pulse_chk();
        chk("R7 no hit when off", retune_hit, 0);
        chk("R7 pend kept", retune_pend, 1);

        // R8: start clears the pending error.
        run({8'hE1, 8'hE1}, 1, 6, "R6 success");
        chk("R8 pend cleared", retune_pend, 0);
        chk("R6 enable set", retune_en, 1);
        pulse_err();
        @(negedge clk); retune_chk = 1;
        @(negedge clk); retune_chk = 0;
        chk("R7 hit", retune_hit, 1);
        chk("R7 pend cleared", retune_pend, 0);

        pulse_err();
        @(negedge clk); start = 1; retune_err = 1; probe_map = {8'hE1, 8'hE1};
        @(negedge clk); start = 0; retune_err = 0;
        chk("R8 clear beats set", retune_pend, 0);
        repeat (20) @(negedge clk);

        // R9: 4-tap entry with halving, upper probes ignored.
        @(negedge clk); four_tap_opt = 1; ddr_enter = 1;
        @(negedge clk); ddr_enter = 0; four_tap_opt = 0;
        chk("R9 mode on", ddr_active, 1);
        chk("R9 tap halved", tap_set, 3);
        run({8'h00, 8'hEE}, 1, 2, "R9 ddr select");
        @(negedge clk); start = 1; probe_map = 16'h00FF;
        @(negedge clk); start = 0;
        repeat (2) @(negedge clk);
        ddr_leave = 1; @(negedge clk); ddr_leave = 0;
        chk("R9 leave ignored busy", ddr_active, 1);
        repeat (12) @(negedge clk);
        chk("R9 ddr full", tap_set, 3);
        ddr_leave = 1; @(negedge clk); ddr_leave = 0;
        chk("R9 mode off", ddr_active, 0);
        ddr_enter = 1; @(negedge clk); ddr_enter = 0;
        chk("R9 no halve", tap_set, 3);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule